// File: doc/BRIEF.md
# Shared Time-Base Multi-Channel PWM Generator

This block drives a small bank of active-high pulse-width-modulated outputs. All channels share one 8-bit divider and one 8-bit period counter. Every period therefore lasts exactly 256 local ticks, and the only way to change the period length is the shared divider value. Each channel has its own 8-bit compare value that sets how long its output stays high at the start of each period.

Software programs the block through a plain write/read strobe port. A control word holds the divider, which is split into two nibble fields, and one global run bit. One word per channel holds that channel's compare value. Programmed values are held in shadow storage and become active only at a period boundary, so a running output never produces a shortened or stretched pulse.

A two-state controller sets the sequencing. In IDLE the divider and counter are held at zero, every output is low, and the shadow values are copied into the active set on every clock. The START transition (IDLE to RUN) is taken when the stored run bit is 1. In RUN the divider and counter advance. The STOP transition (RUN to IDLE) is taken as soon as the stored run bit is 0.

Top module: `pwm_bank`

## Requirements
- R1: After reset all outputs are low, and every register reads zero: the run bit, the divider and all compare values.
- R2: The compare value of channel c is at byte offset 4*c, and only its low 8 bits are stored. The control word is at offset 0x20. Its bits 3:0 hold divider bits 3:0, bit 9 is the run bit, and bits 14:11 hold divider bits 7:4. All other control bits read as zero. Reads are combinational while rd_en is high, and rdata is zero while rd_en is low.
- R3: With divider value ps, one local tick lasts ps+1 clocks, so one period lasts 256*(ps+1) clocks.
- R4: A channel is high while the period counter is at or below its compare value. A compare value d therefore gives d+1 high ticks at the start of each period, and d = 0 gives exactly one tick.
- R5: A compare value of 255 keeps the output high for the whole time the block runs.
- R6: All channels share the time base and rise together at each period start, but each falls according to its own compare value.
- R7: When the stored run bit is 0, every output is low from the next clock on, and the counter and divider are held at zero. Once the stored run bit reads 1, the outputs follow the first period starting one clock later.
- R8: While running, new compare and divider values are adopted only when the counter wraps from 255 to 0. While stopped, they are adopted immediately.
- R9: Writes to unmapped offsets change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe; gates rdata |
| addr | input | AW (8) | Byte offset of the register accessed |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Combinational read data |
| pwm_out | output | NCH (4) | Active-high channel outputs |

## Verification
The assertions check several properties on every clock. Outputs fall silent one clock after the run bit clears. The counter holds at zero while stopped and otherwise advances in unit steps. Every channel is high at count zero. Shadow values are loaded only at a wrap or while stopped. Some properties need whole periods of stimulus and are shown only by the bench scenarios: exact pulse widths and period lengths for several divider values, including one that uses the high divider nibble; the never-low output at compare 255; the register layout on readback; and the fact that a value written mid-pulse leaves the current pulse untouched. The bench compares its own tick-level model against every output on every clock.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int CNT_W   = 8;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter logic [AW-1:0] CTRL_OFF = 'h20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output logic                        run_bit,
    output logic [CNT_W-1:0]            div_val,
    output logic [NCH-1:0][CNT_W-1:0]   duty_val
);
    localparam int PS_LO   = 0;
    localparam int RUN_POS = 9;
    localparam int PS_HI   = 11;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{wdata[DW-1:15], wdata[10], wdata[8]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_bit  <= 1'b0;
            div_val  <= '0;
            duty_val <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_OFF) begin
                run_bit      <= wdata[RUN_POS];
                div_val[3:0] <= wdata[PS_LO+3:PS_LO];
                div_val[7:4] <= wdata[PS_HI+3:PS_HI];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == AW'(4 * c)) begin
                    duty_val[c] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == CTRL_OFF) begin
                rdata[PS_LO+3:PS_LO] = div_val[3:0];
                rdata[RUN_POS]       = run_bit;
                rdata[PS_HI+3:PS_HI] = div_val[7:4];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == AW'(4 * c)) begin
                    rdata[CNT_W-1:0] = duty_val[c];
                end
            end
        end
    end
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic [CNT_W-1:0] div_val,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);
    run_state_e      state_q, state_d;
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] div_act_q;
    logic             tick;
    logic             wrap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: START when run bit set, STOP when cleared
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_bit)  state_d = ST_RUN;
            ST_RUN:  if (!run_bit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign tick = (pre_q == div_act_q);
    assign wrap = tick && (cnt == CNT_W'(CNT_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            cnt       <= '0;
            div_act_q <= '0;
        end else if (state_q == ST_IDLE) begin
            pre_q     <= '0;
            cnt       <= '0;
            div_act_q <= div_val;
        end else if (tick) begin
            pre_q <= '0;
            cnt   <= cnt + 1'b1;
            if (wrap) div_act_q <= div_val;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        run  = (state_q == ST_RUN);
        load = (state_q == ST_IDLE) || wrap;
    end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_val,
    output logic             pwm
);
    logic [CNT_W-1:0] duty_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    duty_act_q <= '0;
        else if (load) duty_act_q <= duty_val;
    end

    always_comb begin
        pwm = run && (cnt <= duty_act_q);
    end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pwm_out
);
    logic                      ctrl_en;
    logic [CNT_W-1:0]          div_val;
    logic [NCH-1:0][CNT_W-1:0] duty_val;
    logic                      run;
    logic                      load;
    logic [CNT_W-1:0]          cnt;

    pwm_bank_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .run_bit  (ctrl_en),
        .div_val  (div_val),
        .duty_val (duty_val)
    );

    pwm_bank_timebase u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_bit (ctrl_en),
        .div_val (div_val),
        .run     (run),
        .cnt     (cnt),
        .load    (load)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .load     (load),
            .cnt      (cnt),
            .duty_val (duty_val[g]),
            .pwm      (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ctrl_en,
    input logic           run,
    input logic           load,
    input logic [7:0]     cnt,
    input logic [NCH-1:0] pwm_out
);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (pwm_out == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == 8'd0));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(cnt)) |-> (cnt == $past(cnt) + 8'd1));

    // R4
    zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == 8'd0) |-> (pwm_out == '1));

    // R8
    load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!run || cnt == 8'hFF));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_en (ctrl_en),
    .run     (run),
    .load    (load),
    .cnt     (cnt),
    .pwm_out (pwm_out)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [7:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] exp_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_run, m_en, m_pre, m_cnt, m_ps_prog, m_ps_act;
    int m_dprog[NCH];
    int m_dact[NCH];

    always #10 clk = ~clk;

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural tick model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_en = 0; m_pre = 0; m_cnt = 0; m_ps_prog = 0; m_ps_act = 0;
            for (int i = 0; i < NCH; i++) begin m_dprog[i] = 0; m_dact[i] = 0; end
        end else begin
            if (!m_run) begin
                m_pre = 0; m_cnt = 0; m_ps_act = m_ps_prog;
                for (int i = 0; i < NCH; i++) m_dact[i] = m_dprog[i];
            end else if (m_pre == m_ps_act) begin
                m_pre = 0;
                if (m_cnt == 255) begin
                    m_cnt = 0; m_ps_act = m_ps_prog;
                    for (int i = 0; i < NCH; i++) m_dact[i] = m_dprog[i];
                end else m_cnt++;
            end else m_pre++;
            m_run = m_en;
            if (wr_en) begin
                if (addr == 8'h20) begin
                    m_en = wdata[9];
                    m_ps_prog = int'(wdata[3:0]) + 16 * int'(wdata[14:11]);
                end
                for (int i = 0; i < NCH; i++)
                    if (int'(addr) == 4 * i) m_dprog[i] = int'(wdata[7:0]);
            end
        end
    end

    // per-cycle comparison (R4, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) exp_out[i] = (m_run != 0) && (m_cnt <= m_dact[i]);
            check(pwm_out == exp_out, "R4 per-cycle output vs model", pwm_out, exp_out);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #2; check(rdata == exp, tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic wait_rise(input int ch);
        do @(negedge clk); while (pwm_out[ch] !== 1'b0);
        do @(negedge clk); while (pwm_out[ch] !== 1'b1);
    endtask

    task automatic high_len(input int ch, output int n);
        wait_rise(ch);
        n = 1;
        forever begin
            @(negedge clk);
            if (pwm_out[ch]) n++; else break;
        end
    endtask

    task automatic period_len(input int ch, output int n);
        wait_rise(ch);
        n = 1;
        do begin @(negedge clk); n++; end while (pwm_out[ch] === 1'b1);
        do begin @(negedge clk); n++; end while (pwm_out[ch] === 1'b0);
        n--;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(pwm_out == '0, "R1 outputs low after reset", pwm_out, 0);
        rd_chk(8'h00, 32'h0, "R1 duty reset value");
        rd_chk(8'h20, 32'h0, "R1 control reset value");

        // R2 register layout
        wr(8'h00, 32'h1234_56AB);
        wr(8'h04, 32'h11);
        wr(8'h08, 32'h22);
        wr(8'h0C, 32'h33);
        rd_chk(8'h00, 32'hAB, "R2 duty0 low byte only");
        rd_chk(8'h0C, 32'h33, "R2 duty3 readback");
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk(8'h20, 32'h0000_7A0F, "R2 control field positions");
        wr(8'h20, 32'h0);
        @(negedge clk); rd_en = 1'b0; addr = 8'h00; #2;
        check(rdata == 32'h0, "R2 rdata zero without rd_en", rdata, 0);

        // R9 unmapped offsets
        wr(8'h30, 32'h55);
        wr(8'h01, 32'h77);
        rd_chk(8'h30, 32'h0, "R9 unmapped read zero");
        rd_chk(8'h00, 32'hAB, "R9 unmapped write ignored");

        // R7 stopped: outputs stay low
        lows = 0;
        repeat (40) begin @(negedge clk); if (pwm_out != '0) lows++; end
        check(lows == 0, "R7 outputs low while stopped", lows, 0);

        // R6 distinct duties, divider 0
        wr(8'h00, 32'd0);
        wr(8'h04, 32'd9);
        wr(8'h08, 32'd127);
        wr(8'h0C, 32'd255);
        wr(8'h20, 32'h200);
        check(pwm_out == '0, "R7 still low the cycle run bit is stored", pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 4'hF, "R7 all channels rise one clock later", pwm_out, 4'hF);
        high_len(0, n); check(n == 1, "R4 duty 0 one tick", n, 1);
        high_len(1, n); check(n == 10, "R6 channel 1 high width", n, 10);
        high_len(2, n); check(n == 128, "R6 channel 2 high width", n, 128);
        period_len(1, n); check(n == 256, "R3 period with divider 0", n, 256);
        lows = 0;
        repeat (600) begin @(negedge clk); if (!pwm_out[3]) lows++; end
        check(lows == 0, "R5 duty 255 never low", lows, 0);

        // R3 split divider 0x12 -> 19 clocks per tick
        wr(8'h00, 32'd10);
        wr(8'h20, 32'h200 | (32'h1 << 11) | 32'h2);
        period_len(0, n); check(n == 4864, "R3 period with divider 0x12", n, 4864);
        high_len(0, n); check(n == 209, "R3 high width with divider 0x12", n, 209);

        // R8 mid-pulse update
        wr(8'h20, 32'h200);
        wr(8'h00, 32'd100);
        wait_rise(0);
        wait_rise(0);
        n = 1;
        forever begin
            @(negedge clk);
            if (n == 10) begin wr_en = 1'b1; addr = 8'h00; wdata = 32'd20; end
            else wr_en = 1'b0;
            if (pwm_out[0]) n++; else break;
        end
        wr_en = 1'b0;
        check(n == 101, "R8 current pulse keeps old duty", n, 101);
        high_len(0, n); check(n == 21, "R8 next pulse uses new duty", n, 21);

        // R7 stop, R8 immediate adoption while stopped
        wr(8'h20, 32'h0);
        @(negedge clk);
        lows = 0;
        repeat (30) begin @(negedge clk); if (pwm_out != '0) lows++; end
        check(lows == 0, "R7 outputs low after stop", lows, 0);
        wr(8'h00, 32'd5);
        wr(8'h20, 32'h200);
        high_len(0, n); check(n == 6, "R8 value adopted while stopped", n, 6);

        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule